// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host hands it one word at a time through a valid/ready request port. The block then runs a read or a write on the RAM pins and holds each pin level for a whole number of clock cycles. Every count comes from the clock period and a nanosecond limit, each given as a parameter, and is rounded up. A read returns its byte through a one-cycle response pulse.

Every RAM pin and the data-drive enable come straight from flip-flops. The shared data bus is split into an output byte, a drive enable and an input byte, so the pad ring can form the tristate. Between requests the chip stays deselected, which keeps the RAM in standby. During writes output enable stays high, so the RAM never drives the bus while the block does. The block turns its own driver on only after the RAM has had time to let go of the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: From reset, and in every cycle with no request in progress, ram_cs_no, ram_we_no and ram_oe_no are 1, ram_dq_oe_o is 0 and req_ready_o is 1.
- R2: A read holds ram_cs_no=0, ram_oe_no=0 and ram_we_no=1 for RD_CYC = ceil(T_RC_NS/CLK_PERIOD_NS) consecutive cycles (14 at defaults), starting the cycle after acceptance, with ram_addr_o equal to the request address.
- R3: rsp_valid_o is 1 for exactly the one cycle after the last read cycle. rsp_rdata_o then holds the ram_dq_i value present in that last cycle.
- R4: A write holds ram_cs_no=0 and ram_we_no=0 for WE_CYC = max(ceil(T_WP_NS/clk), ceil(T_DIS_NS/clk)+ceil(T_DS_NS/clk)) cycles (11 at defaults), starting the cycle after acceptance. ram_oe_no stays 1 throughout.
- R5: During a write, ram_dq_oe_o is 1 from cycle DIS_CYC = ceil(T_DIS_NS/clk) (5) through cycle WE_CYC (11), counted from 0 at the first write cycle. It covers one cycle after ram_we_no rises. ram_dq_o equals the request data whenever ram_dq_oe_o is 1.
- R6: A write keeps ram_addr_o at the request address and req_ready_o at 0 for WR_CYC = max(ceil(T_WC_NS/clk), WE_CYC+1) cycles (14).
- R7: ram_dq_oe_o is never 1 while ram_oe_no is 0. ram_dq_oe_o is 0 in the cycle before any fall of ram_oe_no.
- R8: A request is taken at a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the cycle after acceptance until the cycle after the operation's last cycle. Requests presented while req_ready_o is 0 are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle read data pulse |
| rsp_rdata_o | output | 8 | Read byte |
| ram_addr_o | output | 15 | RAM address pins |
| ram_cs_no | output | 1 | RAM chip select, active low |
| ram_we_no | output | 1 | RAM write enable, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_dq_o | output | 8 | Byte driven onto the data bus |
| ram_dq_oe_o | output | 1 | Data bus drive enable |
| ram_dq_i | input | 8 | Byte read from the data bus |

## Verification
The hardest cases to reach are direction changes on the shared bus with no idle time between them. A read that follows a write the very next time ready is high checks that the driver is released before output enable falls. A write right after a read checks that the driver waits while the RAM lets go. The stimulus holds req_valid_i high across chained requests of mixed direction, so each new operation starts in the first cycle ready allows. A pin-level RAM model in the bench stores bytes only on the end of the write-enable and chip-select overlap, and it flags any cycle where both sides drive.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } sram_op_e;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (clr_i)      nxt_o = '0;
    else if (run_i) nxt_o = cnt_q + CNT_W'(1);
    else            nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sram_pin_decode.sv
`timescale 1ns/1ps
module sram_pin_decode
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned WE_CYC  = 11,
  parameter int unsigned DIS_CYC = 5
) (
  input  sram_op_e         op_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cs_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o
);
  localparam logic [CNT_W-1:0] WE_END = CNT_W'(WE_CYC);
  localparam logic [CNT_W-1:0] DQ_ON  = CNT_W'(DIS_CYC);

  // levels for the cycle that op_i/cnt_i describe
  always_comb begin
    cs_n_o  = 1'b1;
    we_n_o  = 1'b1;
    oe_n_o  = 1'b1;
    dq_oe_o = 1'b0;
    unique case (op_i)
      ST_RD: begin
        cs_n_o = 1'b0;
        oe_n_o = 1'b0;
      end
      ST_WR: begin
        cs_n_o  = !(cnt_i < WE_END);
        we_n_o  = !(cnt_i < WE_END);
        dq_oe_o = (cnt_i >= DQ_ON) && (cnt_i <= WE_END);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [DW-1:0] dq_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= take_i;
      if (take_i) rsp_rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 15,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_WP_NS       = 55,
  parameter int unsigned T_DS_NS       = 30,
  parameter int unsigned T_DIS_NS      = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_cs_no,
  output logic          ram_we_no,
  output logic          ram_oe_no,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  input  logic [DW-1:0] ram_dq_i
);
  localparam int unsigned RD_CYC  = umax(cdiv(T_RC_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned DIS_CYC = cdiv(T_DIS_NS, CLK_PERIOD_NS);
  localparam int unsigned DS_CYC  = umax(cdiv(T_DS_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned WE_CYC  = umax(cdiv(T_WP_NS, CLK_PERIOD_NS), DIS_CYC + DS_CYC);
  localparam int unsigned WR_CYC  = umax(cdiv(T_WC_NS, CLK_PERIOD_NS), WE_CYC + 1);
  localparam int unsigned CNT_W   = $clog2(umax(RD_CYC, WR_CYC) + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);

  sram_op_e         state_q, nxt_state;
  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  logic             accept, rd_done;
  logic             pin_cs_n, pin_we_n, pin_oe_n, pin_dq_oe;
  logic             cs_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign rd_done     = (state_q == ST_RD) && (cnt_q == RD_LAST);

  always_comb begin
    nxt_state = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) nxt_state = req_we_i ? ST_WR : ST_RD;
      ST_RD:   if (cnt_q == RD_LAST) nxt_state = ST_IDLE;
      ST_WR:   if (cnt_q == WR_LAST) nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .run_i  (state_q != ST_IDLE),
    .cnt_o  (cnt_q),
    .nxt_o  (nxt_cnt)
  );

  // pin levels decoded one cycle ahead, then registered
  sram_pin_decode #(
    .CNT_W   (CNT_W),
    .WE_CYC  (WE_CYC),
    .DIS_CYC (DIS_CYC)
  ) u_decode (
    .op_i    (nxt_state),
    .cnt_i   (nxt_cnt),
    .cs_n_o  (pin_cs_n),
    .we_n_o  (pin_we_n),
    .oe_n_o  (pin_oe_n),
    .dq_oe_o (pin_dq_oe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= nxt_state;
      cs_n_q  <= pin_cs_n;
      we_n_q  <= pin_we_n;
      oe_n_q  <= pin_oe_n;
      dq_oe_q <= pin_dq_oe;
      if (accept)             addr_q  <= req_addr_i;
      if (accept && req_we_i) wdata_q <= req_wdata_i;
    end
  end

  sram_rd_capture #(.DW(DW)) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (rd_done),
    .dq_i        (ram_dq_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  assign ram_addr_o  = addr_q;
  assign ram_cs_no   = cs_n_q;
  assign ram_we_no   = we_n_q;
  assign ram_oe_no   = oe_n_q;
  assign ram_dq_o    = wdata_q;
  assign ram_dq_oe_o = dq_oe_q;

  // pulse-width monitors for the assertions
  logic [CNT_W-1:0] we_run_q, oe_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run_q <= '0;
      oe_run_q <= '0;
    end else begin
      we_run_q <= ram_we_no ? '0 : we_run_q + CNT_W'(1);
      oe_run_q <= ram_oe_no ? '0 : oe_run_q + CNT_W'(1);
    end
  end

  assert_idle_deselect_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ram_cs_no && ram_we_no && ram_oe_no && !ram_dq_oe_o));
  assert_read_levels_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_no |-> (!ram_cs_no && ram_we_no));
  assert_oe_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_oe_no) |-> (oe_run_q >= CNT_W'(RD_CYC)));
  assert_rsp_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_write_levels_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> (ram_oe_no && !ram_cs_no));
  assert_we_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> (we_run_q == CNT_W'(WE_CYC)));
  assert_dq_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_dq_oe_o && $past(ram_dq_oe_o)) |-> $stable(ram_dq_o));
  assert_addr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_cs_no && !$past(ram_cs_no)) |-> $stable(ram_addr_o));
  assert_no_fight_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_dq_oe_o && !ram_oe_no));
  assert_turnaround_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_oe_no) |-> !$past(ram_dq_oe_o));
  assert_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_cs_no || ram_dq_oe_o) |-> !req_ready_o);
endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int CLK_NS = 5;
  localparam int RD_CYC  = (70 + CLK_NS - 1) / CLK_NS;
  localparam int DIS_CYC = (25 + CLK_NS - 1) / CLK_NS;
  localparam int DS_CYC  = (30 + CLK_NS - 1) / CLK_NS;
  localparam int WP_CYC  = (55 + CLK_NS - 1) / CLK_NS;
  localparam int WE_CYC  = (WP_CYC > DIS_CYC + DS_CYC) ? WP_CYC : DIS_CYC + DS_CYC;
  localparam int WC_CYC  = (70 + CLK_NS - 1) / CLK_NS;
  localparam int WR_CYC  = (WC_CYC > WE_CYC + 1) ? WC_CYC : WE_CYC + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] ram_addr;
  logic        ram_cs_n, ram_we_n, ram_oe_n, dq_oe;
  logic [7:0]  dq_out;
  logic [7:0]  dq_in = 8'hzz;

  always #2.5 clk = ~clk;

  sram_async_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ram_addr_o(ram_addr), .ram_cs_no(ram_cs_n), .ram_we_no(ram_we_n),
    .ram_oe_no(ram_oe_n), .ram_dq_o(dq_out), .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_in)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  // pin-level RAM model
  logic [7:0] ram_mem [int];
  logic [7:0] ref_mem [int];
  logic prev_cs_n = 1'b1, prev_we_n = 1'b1;

  // reference model state
  int          m_mode = 0;  // 0 idle, 1 read, 2 write
  int          m_k = 0;
  logic [14:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  logic        e_rsp = 1'b0;
  logic [7:0]  e_rdata = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_k = 0; e_rsp = 1'b0;
    end else begin
      e_rsp = 1'b0;
      if (m_mode == 0) begin
        if (req_valid) begin
          m_mode = req_we ? 2 : 1;
          m_k = 0;
          m_addr = req_addr;
          m_data = req_wdata;
          if (req_we) ref_mem[int'(req_addr)] = req_wdata;
        end
      end else if (m_mode == 1) begin
        if (m_k == RD_CYC - 1) begin
          e_rsp = 1'b1;
          e_rdata = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : init_byte(int'(m_addr));
          m_mode = 0;
        end else m_k++;
      end else begin
        if (m_k == WR_CYC - 1) m_mode = 0;
        else m_k++;
      end
    end
  end

  always @(negedge clk) begin
    logic e_cs, e_we, e_oe, e_dqoe, e_rdy;
    // RAM: store at end of the write-enable / chip-select overlap
    if (!prev_cs_n && !prev_we_n && (ram_cs_n || ram_we_n)) begin
      if (!dq_oe) begin
        n_chk++; n_fail++;
        $display("FAIL R5 write edge without drive: got dq_oe %b expected 1", dq_oe);
      end
      ram_mem[int'(ram_addr)] = dq_out;
    end
    prev_cs_n = ram_cs_n;
    prev_we_n = ram_we_n;
    if (!ram_cs_n && ram_we_n && !ram_oe_n)
      dq_in = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : init_byte(int'(ram_addr));
    else
      dq_in = 8'hzz;
    if (rst_n) begin
      e_cs = 1; e_we = 1; e_oe = 1; e_dqoe = 0; e_rdy = 1;
      if (m_mode == 1) begin
        e_cs = 0; e_oe = 0; e_rdy = 0;
      end else if (m_mode == 2) begin
        e_cs = !(m_k < WE_CYC); e_we = !(m_k < WE_CYC);
        e_dqoe = (m_k >= DIS_CYC) && (m_k <= WE_CYC); e_rdy = 0;
      end
      // R1 R8: ready; R2 R4: pin levels; R5 drive; R6 address; R3 response
      chk("R8", "req_ready_o", 32'(req_ready), 32'(e_rdy));
      chk(m_mode == 2 ? "R4" : (m_mode == 1 ? "R2" : "R1"), "cs/we/oe",
          {29'd0, ram_cs_n, ram_we_n, ram_oe_n}, {29'd0, e_cs, e_we, e_oe});
      chk(m_mode == 0 ? "R1" : "R5", "ram_dq_oe_o", 32'(dq_oe), 32'(e_dqoe));
      if (m_mode != 0) chk(m_mode == 2 ? "R6" : "R2", "ram_addr_o", 32'(ram_addr), 32'(m_addr));
      if (e_dqoe) chk("R5", "ram_dq_o", 32'(dq_out), 32'(m_data));
      chk("R3", "rsp_valid_o", 32'(rsp_valid), 32'(e_rsp));
      if (e_rsp) chk("R3", "rsp_rdata_o", 32'(rsp_rdata), 32'(e_rdata));
      if (dq_oe && !ram_oe_n) begin
        n_chk++; n_fail++;
        $display("FAIL R7 bus contention: got dq_oe=1 oe_n=0 expected no overlap");
      end
    end
  end

  task automatic do_req(input bit we, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk("R1", "reset cs_n", 32'(ram_cs_n), 32'd1);
    chk("R1", "reset we_n", 32'(ram_we_n), 32'd1);
    chk("R1", "reset oe_n", 32'(ram_oe_n), 32'd1);
    chk("R1", "reset dq_oe", 32'(dq_oe), 32'd0);
    chk("R3", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reads of unwritten boundary addresses
    do_req(0, 15'h0000, 8'h00);
    go_idle(20);
    do_req(0, 15'h7FFF, 8'h00);
    go_idle(2);
    // back-to-back writes then back-to-back reads (write to read turnaround, R7)
    do_req(1, 15'h0000, 8'hA5);
    do_req(1, 15'h7FFF, 8'h3C);
    do_req(0, 15'h0000, 8'h00);
    do_req(0, 15'h7FFF, 8'h00);
    // read then write with no gap, then read back
    do_req(0, 15'h1234, 8'h00);
    do_req(1, 15'h1234, 8'h77);
    do_req(0, 15'h1234, 8'h00);
    do_req(1, 15'h1234, 8'h88);
    do_req(0, 15'h1234, 8'h00);
    go_idle(5);
    // R8: requests made while busy are held off; mixed pattern with gaps
    for (int i = 0; i < 40; i++) begin
      logic [14:0] a;
      a = 15'((i * 2731 + 17) & 15'h0FF) | 15'h4000;
      do_req((i % 3) != 2, a, 8'((i * 37) ^ 8'hC3));
      if (i % 5 == 4) go_idle(i % 4);
    end
    for (int i = 0; i < 40; i++) begin
      do_req(0, 15'((i * 2731 + 17) & 15'h0FF) | 15'h4000, 8'h00);
    end
    go_idle(30);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule